// File: doc/BRIEF.md
# Model-Specific Register and Port I/O Permission Bitmap Checker

This block decides whether a guest's access to a model-specific register (MSR) or to an I/O port must leave the guest and return to the hypervisor. The decision comes from permission bitmaps that software keeps in memory. For each lookup the block works out the bitmap address, fetches one 16-bit word over a simple request/response memory port, and tests the relevant bits. It then reports exit or no exit, together with the two exit-information words the hypervisor needs.

An MSR lookup takes a 32-bit MSR number and a read/write flag. MSR numbers fall into three disjoint windows, and each window maps onto its own region of the MSR bitmap with two bits per MSR. Any number outside those windows exits at once, with no memory access. An I/O lookup takes a port number, a 32-bit access descriptor carrying the access size, and the next-instruction pointer. The size becomes a multi-bit mask that may cross a byte boundary. The I/O check happens only when I/O interception is enabled. Otherwise the lookup finishes at once with no exit.

Only one lookup is in flight at a time. A busy output holds off new requests until the memory response has arrived.

Top module: `perm_bitmap_checker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are low.
- R2: An MSR number maps to an index. For MSRs 0x0000_0000..0x0000_1FFF the index is the MSR number. For 0xC000_0000..0xC000_1FFF it is 8192 + (msr − 0xC000_0000). For 0xC001_0000..0xC001_1FFF it is 16384 + (msr − 0xC001_0000). The byte fetched is at `msr_base` + index/4.
- R3: The tested bit of an MSR lookup is bit (index mod 4)·2 + `msr_write` of the low byte `mem_rsp_data[7:0]`, where `msr_write` is 0 for a read and 1 for a write. The lookup exits when that bit is 1. On an MSR exit, `exit_info1` = `msr_write` and `exit_info2` = 0.
- R4: An MSR number outside all three windows gives `done` with `exit_flag`=1 and `exit_info1`=`msr_write` in the cycle after acceptance, and no memory request is issued.
- R5: An I/O lookup fetches the word at `io_base` + port/8. `mem_rsp_data[7:0]` holds the byte at that address and `mem_rsp_data[15:8]` holds the next byte.
- R6: The I/O size is `io_param[6:4]`. The mask is ((1<<size)−1) << (port mod 8), applied to the 16-bit word, so it may span both bytes. The lookup exits if any masked bit is 1. A size of 0 never exits.
- R7: On an I/O exit, `exit_info1` = {32'b0, `io_param`} | (port << 16) and `exit_info2` = `next_ip`. Whenever `done` is high with `exit_flag`=0, both info words are 0.
- R8: With `io_enable` low, an I/O lookup gives `done` with `exit_flag`=0 in the cycle after acceptance, and no memory request is issued.
- R9: A request is accepted when `req_valid` is high and `busy` is low. For a lookup that needs memory, `mem_req_valid` pulses for exactly the cycle after acceptance, and `busy` is high from that cycle until `mem_rsp_valid` is seen. `done` pulses for one cycle, in the cycle after the response.
- R10: `req_valid` while `busy` is high is ignored and does not alter the pending result. `mem_rsp_valid` while no lookup waits is ignored and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_kind | input | 1 | 0 = MSR lookup, 1 = I/O lookup |
| msr_num | input | 32 | MSR number |
| msr_write | input | 1 | 0 = read access, 1 = write access |
| io_port | input | 16 | I/O port number |
| io_param | input | 32 | I/O access descriptor, size in bits [6:4] |
| next_ip | input | 64 | Next-instruction pointer for I/O exits |
| msr_base | input | ADDR_W | MSR bitmap byte base address |
| io_base | input | ADDR_W | I/O bitmap byte base address |
| io_enable | input | 1 | I/O interception enabled |
| busy | output | 1 | Lookup outstanding |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | ADDR_W | Byte address of the 16-bit word to read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 16 | Read word, lower address in bits [7:0] |
| done | output | 1 | Result valid pulse |
| exit_flag | output | 1 | Access must exit |
| exit_info1 | output | 64 | First exit-information word |
| exit_info2 | output | 64 | Second exit-information word |

## Verification
Lookups that finish without memory (an MSR outside the windows, or I/O with interception off) have their result due one cycle after the accepting edge. The bench checks that result at the falling edge right after that edge, together with the absence of a memory request. For memory lookups, the request address and `busy` are checked at the first falling edge after acceptance. The response is then held back for zero to three random cycles, and `done` is checked to stay low throughout. The verdict and info words are sampled at the falling edge after the response edge, and the following falling edge confirms that `done` has dropped.

// File: rtl/pbc_pkg.sv
// Shared types for the permission bitmap checker.
// Assumes: one lookup in flight, 16-bit memory read word.
package pbc_pkg;

    localparam int WORD_W = 16;
    localparam int INFO_W = 64;

    typedef enum logic {
        KIND_MSR = 1'b0,
        KIND_IO  = 1'b1
    } lookup_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    // Everything the evaluation stage needs once the bitmap word arrives.
    typedef struct packed {
        lookup_kind_e      kind;
        logic [2:0]        bit_sel;
        logic [WORD_W-1:0] mask;
        logic [INFO_W-1:0] info1;
        logic [INFO_W-1:0] info2;
    } pend_t;

endpackage

// File: rtl/pbc_msr_decode.sv
// MSR window decoder: maps an MSR number onto a bitmap index,
// then onto a byte address and a bit position in that byte.
// Assumes: windows are disjoint and each WIN_SIZE is a multiple of 4.
module pbc_msr_decode #(
    parameter int ADDR_W   = 48,
    parameter int WIN_CNT  = 3,
    parameter int WIN_SIZE = 8192,
    parameter logic [WIN_CNT-1:0][31:0] WIN_BASE =
        {32'hC001_0000, 32'hC000_0000, 32'h0000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       msr_num,
    input  logic              msr_write,
    input  logic [ADDR_W-1:0] base,
    output logic              in_window,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_sel
);
    localparam int IDX_W = $clog2(WIN_CNT * WIN_SIZE);

    logic [WIN_CNT-1:0]            hit;
    logic [WIN_CNT-1:0][IDX_W-1:0] idx_w;
    logic [IDX_W-1:0]              idx;

    // One comparator and index adder per window.
    for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
        logic [31:0] rel;
        assign rel      = msr_num - WIN_BASE[w];
        assign hit[w]   = (msr_num >= WIN_BASE[w]) && (rel < 32'(WIN_SIZE));
        assign idx_w[w] = IDX_W'(w * WIN_SIZE) + rel[IDX_W-1:0];
    end

    // Select the index of the window that matched.
    always_comb begin
        idx = '0;
        for (int w = 0; w < WIN_CNT; w++) begin
            if (hit[w]) idx = idx | idx_w[w];
        end
    end

    assign in_window = |hit;
    assign byte_addr = base + ADDR_W'(idx >> 2);
    assign bit_sel   = {idx[1:0], msr_write};

    // R2: an MSR number falls into at most one window.
    p_one_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/pbc_io_decode.sv
// Port I/O decoder: word address of the port's bitmap bits, and the
// access mask derived from the size field, aligned to the port offset.
// Assumes: size field is 3 bits, so the mask spans at most 14 bits.
module pbc_io_decode #(
    parameter int ADDR_W = 48,
    parameter int PORT_W = 16,
    parameter int SIZE_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port,
    input  logic [31:0]       param,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] word_addr,
    output logic [15:0]       mask
);
    logic [2:0] size;
    logic [7:0] raw;

    // Size field and un-shifted mask of 'size' ones.
    always_comb begin
        size = param[SIZE_LSB +: 3];
        raw  = (8'd1 << size) - 8'd1;
    end

    assign word_addr = base + ADDR_W'(port >> 3);
    assign mask      = {8'b0, raw} << port[2:0];

    // R6: the mask carries exactly 'size' ones, whatever the offset.
    p_mask_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == int'(size));

endmodule

// File: rtl/pbc_seq.sv
// Lookup sequencer: accepts a request, finishes at once when no
// bitmap read is needed, else issues one read, waits for the word,
// evaluates the pending bit test and reports the result.
// Assumes: memory accepts every request; exactly one response follows.
module pbc_seq
    import pbc_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              need_mem,
    input  logic              fast_exit,
    input  logic [INFO_W-1:0] fast_info1,
    input  logic [ADDR_W-1:0] addr_next,
    input  pend_t             pend_next,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              done,
    output logic              exit_flag,
    output logic [INFO_W-1:0] exit_info1,
    output logic [INFO_W-1:0] exit_info2
);
    seq_state_e state;
    pend_t      pend_q;
    logic       hit;

    // Bit test on the returned word for the pending lookup.
    always_comb begin
        if (pend_q.kind == KIND_IO) hit = |(mem_rsp_data & pend_q.mask);
        else                        hit = mem_rsp_data[pend_q.bit_sel];
    end

    // State, request pulse and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            pend_q        <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            done          <= 1'b0;
            exit_flag     <= 1'b0;
            exit_info1    <= '0;
            exit_info2    <= '0;
        end else begin
            mem_req_valid <= 1'b0;
            done          <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (need_mem) begin
                            state         <= ST_WAIT;
                            mem_req_valid <= 1'b1;
                            mem_req_addr  <= addr_next;
                            pend_q        <= pend_next;
                        end else begin
                            done       <= 1'b1;
                            exit_flag  <= fast_exit;
                            exit_info1 <= fast_exit ? fast_info1 : '0;
                            exit_info2 <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        exit_flag  <= hit;
                        exit_info1 <= hit ? pend_q.info1 : '0;
                        exit_info2 <= hit ? pend_q.info2 : '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_WAIT);

    // R9: the memory request is a single-cycle pulse.
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R9: done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an accepted memory lookup issues its request and goes busy.
    p_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && need_mem) |=> (mem_req_valid && busy));

    // R9: busy drops only together with a result.
    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4, R8: a lookup without memory completes next cycle, no request.
    p_fast_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !need_mem) |=> (done && !mem_req_valid));

    // R10: while waiting without a response, no result appears.
    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |=> (!done && busy));

    // R10: a stray response while idle produces nothing.
    p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid && mem_rsp_valid) |=> !done);

    // R7: no-exit results carry zero information words.
    p_noexit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !exit_flag) |-> (exit_info1 == '0 && exit_info2 == '0));

endmodule

// File: rtl/perm_bitmap_checker.sv
// Top of the permission bitmap checker: routes an MSR or port I/O
// lookup through its decoder, picks the fast or memory path and
// hands the pending test to the sequencer.
// Assumes: bases are byte addresses; memory word is little-endian.
module perm_bitmap_checker
    import pbc_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int MSR_WINS = 3,
    parameter int MSR_WIN_SIZE = 8192,
    parameter int PORT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [31:0]       msr_num,
    input  logic              msr_write,
    input  logic [PORT_W-1:0] io_port,
    input  logic [31:0]       io_param,
    input  logic [63:0]       next_ip,
    input  logic [ADDR_W-1:0] msr_base,
    input  logic [ADDR_W-1:0] io_base,
    input  logic              io_enable,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [15:0]       mem_rsp_data,
    output logic              done,
    output logic              exit_flag,
    output logic [63:0]       exit_info1,
    output logic [63:0]       exit_info2
);
    localparam int PORT_SHIFT = 16;

    logic              msr_in_window;
    logic [ADDR_W-1:0] msr_byte_addr;
    logic [2:0]        msr_bit_sel;
    logic [ADDR_W-1:0] io_word_addr;
    logic [15:0]       io_mask;

    logic              is_io;
    logic              need_mem;
    logic              fast_exit;
    logic [INFO_W-1:0] fast_info1;
    logic [ADDR_W-1:0] addr_next;
    pend_t             pend_next;

    pbc_msr_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_CNT (MSR_WINS),
        .WIN_SIZE(MSR_WIN_SIZE)
    ) u_msr (
        .clk      (clk),
        .rst_n    (rst_n),
        .msr_num  (msr_num),
        .msr_write(msr_write),
        .base     (msr_base),
        .in_window(msr_in_window),
        .byte_addr(msr_byte_addr),
        .bit_sel  (msr_bit_sel)
    );

    pbc_io_decode #(
        .ADDR_W(ADDR_W),
        .PORT_W(PORT_W)
    ) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .port     (io_port),
        .param    (io_param),
        .base     (io_base),
        .word_addr(io_word_addr),
        .mask     (io_mask)
    );

    // Path choice and the pending test for the selected lookup kind.
    always_comb begin
        is_io      = (req_kind == KIND_IO);
        need_mem   = is_io ? io_enable : msr_in_window;
        fast_exit  = !is_io;
        fast_info1 = {{(INFO_W-1){1'b0}}, msr_write};
        addr_next  = is_io ? io_word_addr : msr_byte_addr;
        pend_next.kind    = is_io ? KIND_IO : KIND_MSR;
        pend_next.bit_sel = msr_bit_sel;
        pend_next.mask    = io_mask;
        if (is_io) begin
            pend_next.info1 = {32'b0, io_param}
                            | (INFO_W'(io_port) << PORT_SHIFT);
            pend_next.info2 = next_ip;
        end else begin
            pend_next.info1 = fast_info1;
            pend_next.info2 = '0;
        end
    end

    pbc_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .need_mem     (need_mem),
        .fast_exit    (fast_exit),
        .fast_info1   (fast_info1),
        .addr_next    (addr_next),
        .pend_next    (pend_next),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .busy         (busy),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .done         (done),
        .exit_flag    (exit_flag),
        .exit_info1   (exit_info1),
        .exit_info2   (exit_info2)
    );

    // R4: an MSR outside every window exits next cycle without a read.
    p_msr_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_kind && !msr_in_window)
        |=> (done && exit_flag && !mem_req_valid));

    // R8: I/O with interception off finishes next cycle, no exit.
    p_io_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_kind && !io_enable)
        |=> (done && !exit_flag && !mem_req_valid));

endmodule

// File: tb/perm_bitmap_checker_test.sv
`timescale 1ns/1ps
module perm_bitmap_checker_test;
    localparam int AW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_kind = 1'b0;
    logic [31:0]   msr_num = '0;
    logic          msr_write = 1'b0;
    logic [15:0]   io_port = '0;
    logic [31:0]   io_param = '0;
    logic [63:0]   next_ip = '0;
    logic [AW-1:0] msr_base = '0;
    logic [AW-1:0] io_base = '0;
    logic          io_enable = 1'b0;
    logic          busy, mem_req_valid, done, exit_flag;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [15:0]   mem_rsp_data = '0;
    logic [63:0]   exit_info1, exit_info2;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;
    int mem_mode = 0;
    logic [7:0] salt = 8'h5A;

    perm_bitmap_checker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .msr_num(msr_num), .msr_write(msr_write), .io_port(io_port),
        .io_param(io_param), .next_ip(next_ip), .msr_base(msr_base),
        .io_base(io_base), .io_enable(io_enable), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .exit_flag(exit_flag), .exit_info1(exit_info1),
        .exit_info2(exit_info2)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Bitmap memory contents as a function of address.
    function automatic logic [7:0] mbyte(logic [AW-1:0] a);
        case (mem_mode)
            1:       return 8'h00;
            2:       return 8'hFF;
            default: return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ salt;
        endcase
    endfunction

    // MSR index per R2; ok=0 outside the windows.
    function automatic int msr_index(logic [31:0] m, output bit ok);
        ok = 1;
        if (m <= 32'h1FFF) return int'(m);
        if (m >= 32'hC000_0000 && m <= 32'hC000_1FFF) return 8192 + int'(m - 32'hC000_0000);
        if (m >= 32'hC001_0000 && m <= 32'hC001_1FFF) return 16384 + int'(m - 32'hC001_0000);
        ok = 0;
        return 0;
    endfunction

    // Drive one MSR lookup and check it.
    task automatic msr_lookup(logic [31:0] m, logic wr, int dly, bit poke);
        bit ok; int idx; logic [AW-1:0] a; int b; logic e;
        idx = msr_index(m, ok);
        a = msr_base + AW'(idx / 4);
        b = (idx % 4) * 2 + int'(wr);
        @(negedge clk);
        req_kind = 1'b0; msr_num = m; msr_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            check("R4 done", 64'(done), 64'd1);
            check("R4 exit", 64'(exit_flag), 64'd1);
            check("R4 no mem request", 64'(mem_req_valid), 64'd0);
            check("R4 info1", exit_info1, 64'(wr));
            check("R4 info2", exit_info2, 64'd0);
            @(negedge clk);
            check("R9 done pulse", 64'(done), 64'd0);
            return;
        end
        check("R9 mem_req_valid", 64'(mem_req_valid), 64'd1);
        check("R9 busy", 64'(busy), 64'd1);
        check("R2 address", 64'(mem_req_addr), 64'(a));
        if (poke) begin
            req_kind = 1'b0; msr_num = 32'h5000_0000; req_valid = 1'b1;
        end
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R10 no early done", 64'(done), 64'd0);
            check("R9 request single pulse", 64'(mem_req_valid), 64'd0);
        end
        mem_rsp_data = {mbyte(a + 1), mbyte(a)};
        mem_rsp_valid = 1'b1;
        req_valid = 1'b0;
        e = mem_rsp_data[b];
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R9 done", 64'(done), 64'd1);
        check("R9 busy low", 64'(busy), 64'd0);
        check("R3 exit", 64'(exit_flag), 64'(e));
        check("R3 info1", exit_info1, e ? 64'(wr) : 64'd0);
        check("R3 info2", exit_info2, 64'd0);
        @(negedge clk);
        check("R9 done pulse", 64'(done), 64'd0);
    endtask

    // Drive one I/O lookup and check it.
    task automatic io_lookup(logic [15:0] p, logic [31:0] prm, logic [63:0] ip,
                             logic en, int dly, bit poke);
        logic [AW-1:0] a; logic [15:0] w, mk; int sz; logic e;
        logic [63:0] i1;
        a = io_base + AW'(p / 8);
        sz = int'(prm[6:4]);
        mk = ((16'd1 << sz) - 16'd1) << (p % 8);
        i1 = {32'b0, prm} | (64'(p) << 16);
        @(negedge clk);
        req_kind = 1'b1; io_port = p; io_param = prm; next_ip = ip;
        io_enable = en; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!en) begin
            check("R8 done", 64'(done), 64'd1);
            check("R8 no exit", 64'(exit_flag), 64'd0);
            check("R8 no mem request", 64'(mem_req_valid), 64'd0);
            check("R7 info1 zero", exit_info1, 64'd0);
            @(negedge clk);
            check("R9 done pulse", 64'(done), 64'd0);
            return;
        end
        check("R9 mem_req_valid", 64'(mem_req_valid), 64'd1);
        check("R5 address", 64'(mem_req_addr), 64'(a));
        if (poke) begin
            req_kind = 1'b1; io_enable = 1'b0; req_valid = 1'b1;
        end
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R10 no early done", 64'(done), 64'd0);
        end
        w = {mbyte(a + 1), mbyte(a)};
        mem_rsp_data = w;
        mem_rsp_valid = 1'b1;
        req_valid = 1'b0;
        e = |(w & mk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R9 done", 64'(done), 64'd1);
        check("R6 exit", 64'(exit_flag), 64'(e));
        check("R7 info1", exit_info1, e ? i1 : 64'd0);
        check("R7 info2", exit_info2, e ? ip : 64'd0);
        @(negedge clk);
        check("R9 done pulse", 64'(done), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

        msr_base = 48'h0000_1234_5000;
        io_base  = 48'h0000_0ABC_0003;

        // Directed MSR window edges (R2, R3, R4).
        mem_mode = 2;
        msr_lookup(32'h0000_0000, 1'b0, 0, 0);
        msr_lookup(32'h0000_1FFF, 1'b1, 1, 0);
        msr_lookup(32'hC000_0000, 1'b0, 2, 0);
        msr_lookup(32'hC000_1FFF, 1'b1, 0, 0);
        msr_lookup(32'hC001_0000, 1'b1, 3, 0);
        msr_lookup(32'hC001_1FFF, 1'b0, 1, 0);
        mem_mode = 1;
        msr_lookup(32'hC001_0005, 1'b1, 1, 0);
        msr_lookup(32'h0000_2000, 1'b1, 0, 0);
        msr_lookup(32'hBFFF_FFFF, 1'b0, 0, 0);
        msr_lookup(32'hC000_2000, 1'b1, 0, 0);
        msr_lookup(32'hC001_2000, 1'b0, 0, 0);

        // Directed I/O corners (R5, R6, R7, R8).
        mem_mode = 2;
        io_lookup(16'h0007, 32'h0000_0040, 64'h1111_2222_3333_4444, 1'b1, 0, 0);
        io_lookup(16'hFFFF, 32'h0000_0010, 64'h0000_0000_0040_1000, 1'b1, 2, 0);
        io_lookup(16'h0100, 32'h0000_0000, 64'h0000_0000_0000_0042, 1'b1, 1, 0);
        io_lookup(16'h0050, 32'h0000_0070, 64'hFFFF_0000_0000_0001, 1'b0, 0, 0);
        mem_mode = 0;
        salt = 8'h01;
        io_lookup(16'h00F7, 32'h0000_0070, 64'h0000_7000_0000_0010, 1'b1, 1, 0);

        // Request while busy, then a stray response while idle (R10).
        msr_lookup(32'hC000_0123, 1'b1, 3, 1);
        io_lookup(16'h03F9, 32'h8000_0020, 64'h0000_0000_1234_5678, 1'b1, 2, 1);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R10 stray response", 64'(done), 64'd0);
        check("R10 stray response busy", 64'(busy), 64'd0);

        // Constrained random mix.
        for (int k = 0; k < 400; k++) begin
            int sel;
            salt = 8'($urandom);
            mem_mode = ($urandom % 8 == 0) ? 2 : 0;
            msr_base = AW'({$urandom, $urandom});
            io_base  = AW'({$urandom, $urandom});
            sel = int'($urandom % 5);
            case (sel)
                0: msr_lookup($urandom % 32'h2000, 1'($urandom), int'($urandom % 4), 1'($urandom));
                1: msr_lookup(32'hC000_0000 + $urandom % 32'h2000, 1'($urandom), int'($urandom % 4), 0);
                2: msr_lookup(32'hC001_0000 + $urandom % 32'h2000, 1'($urandom), int'($urandom % 4), 0);
                3: msr_lookup($urandom, 1'($urandom), 0, 0);
                default: io_lookup(16'($urandom), $urandom, {$urandom, $urandom},
                                   ($urandom % 6 != 0), int'($urandom % 4), 1'($urandom));
            endcase
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule